// File: doc/BRIEF.md
# Clip-and-Round Tensor Quantizer

This block turns a stream of fixed-point real numbers into short integer codes for a reduced-precision neural network. Each sample is a signed Q2.14 value (the real value is the 16-bit two's-complement word divided by 16384). A per-sample mode bit picks weight or activation treatment. The block first limits the sample to a fixed range using comparators only. It then multiplies by a constant that depends on the code width K and rounds to the nearest integer. There is no division, no transcendental function and no scale computed at run time.

Weights come out as signed K-bit codes that are symmetric about zero. Activations come out as unsigned K-bit codes. For K = 1, a weight reduces to its sign bit, and any magnitude factor is applied further downstream. The block is a two-stage pipeline: the first stage clamps and the second scales and rounds. Samples enter through a valid/ready handshake and leave through another one. When the consumer stalls, the whole pipeline holds.

Top module: `clip_round_quantizer`

## Requirements
- R1: In weight mode (`in_mode`=0) the sample is limited to [-1, +1] before scaling. Any input at or beyond +1 (16384) yields code +(2^(K-1)-1), and any input at or below -1 (-16384) yields -(2^(K-1)-1), for K>1.
- R2: In activation mode (`in_mode`=1) the sample is limited to [0, 1]. Any negative input yields code 0, and any input at or above 1 (16384) yields 2^K-1.
- R3: In weight mode with K>1, the code is round((2^(K-1)-1)·w), emitted as K-bit two's complement. The most negative K-bit pattern (MSB 1, other bits 0) is never produced.
- R4: In activation mode, the code is round((2^K-1)·a), emitted as a K-bit unsigned value.
- R5: Rounding is to nearest, and exact ties go away from zero. For example, at K=4 a weight of 0.5 (8192) gives +4, -0.5 gives -4, and an activation of 0.5 gives 8.
- R6: With K=1 in activation mode, the code is 1 for inputs of 0.5 (8192) or more and 0 below that.
- R7: With K=1 in weight mode, the code is 1 for inputs of zero or above and 0 for negative inputs.
- R8: A sample accepted at a clock edge (in_valid and in_ready both high) appears on the output after the following edge, provided the output is not stalled. Samples leave in the order they entered.
- R9: While out_valid is high and out_ready is low, out_code and out_valid hold and in_ready is low. In every other cycle, in_ready is high.
- R10: While rst_n is low and until the first sample arrives, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed Q2.14 sample |
| in_mode | input | 1 | 0 = weight, 1 = activation |
| out_valid | output | 1 | Code present |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | K | Quantized code (signed for weight, unsigned for activation) |

## Verification
The hardest cases to reach are exact rounding ties. A tie needs an input whose product with the odd scale constant lands exactly on a half, such as ±0.5 at K=4. Random values almost never hit these points. Directed samples therefore visit every tie and every clamp boundary in both modes, at K=4 and at K=1. Random data then runs while out_ready toggles, so stalls land on every pipeline occupancy pattern.

// File: rtl/clip_round_quantizer.sv
module clip_round_quantizer #(
  parameter int K    = 4,
  parameter int IN_W = 16,
  parameter int FRAC = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   in_mode,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [K-1:0]           out_code
);
  localparam int PW = IN_W + K;
  localparam logic signed [IN_W-1:0] ONE_S = IN_W'(1 << FRAC);
  localparam logic [K-1:0] SCALE_W = K'((1 << (K-1)) - 1);
  localparam logic [K-1:0] SCALE_A = K'((1 << K) - 1);
  localparam logic [PW-1:0] HALF = PW'(1 << (FRAC-1));

  logic                   adv;
  logic                   s1_v, s1_mode, s1_pos;
  logic signed [IN_W-1:0] s1_x;
  logic                   o_mode;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic signed [IN_W-1:0] lo, clamped;
  assign lo      = in_mode ? '0 : -ONE_S;
  assign clamped = (in_data < lo) ? lo : (in_data > ONE_S) ? ONE_S : in_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_mode <= 1'b0; s1_pos <= 1'b0; s1_x <= '0;
    end else if (adv) begin
      s1_v    <= in_valid;
      s1_mode <= in_mode;
      s1_pos  <= !in_data[IN_W-1];
      s1_x    <= clamped;
    end

  logic            neg;
  logic [IN_W-1:0] mag;
  logic [K-1:0]    scale, qmag, code_n;
  logic [PW-1:0]   prod, rnd;

  assign neg   = s1_x[IN_W-1];
  assign mag   = neg ? IN_W'(-s1_x) : IN_W'(s1_x);
  assign scale = s1_mode ? SCALE_A : SCALE_W;
  assign prod  = {{K{1'b0}}, mag} * {{IN_W{1'b0}}, scale};
  assign rnd   = prod + HALF;
  assign qmag  = rnd[FRAC +: K];
  assign code_n = (!s1_mode && K == 1) ? K'(s1_pos)
                : neg ? K'(0) - qmag : qmag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_code <= '0; o_mode <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_v;
      out_code  <= code_n;
      o_mode    <= s1_mode;
    end
endmodule

module clip_round_quantizer_chk #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [K-1:0] out_code,
  input logic         o_mode
);
  localparam logic [K-1:0] MIN_CODE = K'(1) << (K-1);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_drop_only_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  p_no_min_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !o_mode && K > 1 |-> out_code != MIN_CODE);

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind clip_round_quantizer clip_round_quantizer_chk #(.K(K)) u_chk (.*);

// File: tb/tb_clip_round_quantizer.sv
module tb_clip_round_quantizer;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_mode = 0, out_ready = 1;
  logic signed [15:0] in_data = '0;
  logic rdy4, rdy1, ov4, ov1;
  logic [3:0] code4;
  logic [0:0] code1;
  int checks = 0, fails = 0;
  bit done = 0, rand_ready = 0;

  always #(CLK_P/2) clk = ~clk;

  clip_round_quantizer #(.K(4)) dut (.clk, .rst_n, .in_valid, .in_ready(rdy4),
    .in_data, .in_mode, .out_valid(ov4), .out_ready, .out_code(code4));
  clip_round_quantizer #(.K(1)) dut1 (.clk, .rst_n, .in_valid, .in_ready(rdy1),
    .in_data, .in_mode, .out_valid(ov1), .out_ready, .out_code(code1));

  function automatic int qref(input int x, input bit act, input int k, output string tag);
    int c, m, p, mag, q;
    c = x;
    if (act) begin if (c < 0) c = 0; end
    else if (c < -16384) c = -16384;
    if (c > 16384) c = 16384;
    if (k == 1) begin
      tag = act ? "R6" : "R7";
      if (!act) return (x >= 0) ? 1 : 0;
    end
    m = act ? (1 << k) - 1 : (1 << (k-1)) - 1;
    p = c * m;
    mag = p < 0 ? -p : p;
    q = (mag + 8192) / 16384;
    if (k > 1) begin
      if (c != x || c == 16384 || c == -16384) tag = act ? "R2" : "R1";
      else if (mag % 16384 == 8192) tag = "R5";
      else tag = act ? "R4" : "R3";
    end
    return p < 0 ? -q : q;
  endfunction

  bit m4v1, m4v2, m1v1, m1v2;
  int m4c1, m4c2, m1c1, m1c2;
  string m4t1, m4t2, m1t1, m1t2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m4v1 = 0; m4v2 = 0; m1v1 = 0; m1v2 = 0;
    end else begin
      string t;
      int c;
      if (!m4v2 || out_ready) begin
        m4v2 = m4v1; m4c2 = m4c1; m4t2 = m4t1;
        m4v1 = in_valid; c = qref(int'(in_data), in_mode, 4, t); m4c1 = c & 15; m4t1 = t;
      end
      if (!m1v2 || out_ready) begin
        m1v2 = m1v1; m1c2 = m1c1; m1t2 = m1t1;
        m1v1 = in_valid; c = qref(int'(in_data), in_mode, 1, t); m1c1 = c & 1; m1t1 = t;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!ov4, "R10", ov4, 0);
      check(!ov1, "R10", ov1, 0);
    end else if (!done) begin
      check(ov4 == m4v2, "R8", ov4, m4v2);
      check(ov1 == m1v2, "R8", ov1, m1v2);
      if (m4v2) check(int'(code4) == m4c2, m4t2, code4, m4c2);
      if (m1v2) check(int'(code1) == m1c2, m1t2, code1, m1c2);
      check(rdy4 == (!m4v2 || out_ready), "R9", rdy4, !m4v2 || out_ready);
      check(rdy1 == (!m1v2 || out_ready), "R9", rdy1, !m1v2 || out_ready);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_ready) out_ready = ($urandom % 10) < 6;
    else out_ready = 1;
  end

  task automatic send(input int x, input bit mode);
    in_valid = 1; in_data = 16'(x); in_mode = mode;
    @(negedge clk);
    while (!rdy4) @(negedge clk);
    @(posedge clk); #2;
    in_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int vals[12] = '{0, 16384, -16384, 32767, -32768, 8192, -8192, 8191, -1, 20000, 1, 5461};
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    for (int md = 0; md < 2; md++)
      foreach (vals[i]) send(vals[i], md[0]);
    repeat (4) @(posedge clk);
    rand_ready = 1;
    for (int n = 0; n < 500; n++) begin
      int x;
      x = ($urandom % 2) ? int'($urandom % 32769) - 16384 : int'($signed(16'($urandom)));
      if ($urandom % 5 == 0) begin
        @(posedge clk); #2;
      end
      send(x, $urandom % 2);
    end
    rand_ready = 0;
    repeat (10) @(posedge clk);
    #2;
    check(!ov4 && !ov1, "R8", ov4, 0);
    finish_run();
  end
endmodule